// File: doc/BRIEF.md
# Pipelined Vector Magnitude Unit with Power-of-Two Scaling

This block takes two unsigned component magnitudes, squares each, adds the squares and takes the integer square root of the sum, so that the output is the length of the vector the two components describe. The inputs are fractions in which 0x8000 stands for 1.0. The output uses the same LSB weight, so at unit scale it spans 0 up to just under 2, which leaves room for the longest possible vector of length √2. A new pair may be presented on every clock, and every result appears a fixed 24 clocks after its pair was captured.

A 2-bit scale control shifts the result toward the more significant end by 0, 1, 2 or 3 places. The control is registered on its own and is not carried down the data pipeline, so a new setting acts on the very next output word whatever data that word carries. When the shift pushes a set bit beyond the top of the 16-bit output word, an overflow flag marks that word. The word then holds the low 16 bits of the shifted value.

Top module: `pyth_mag_unit`

## Requirements
- R1: One pair `(x_mag, y_mag)` is captured on every rising clock edge. Each input is an unsigned magnitude in the range 0 to 0x8000, where 0x8000 is 1.0.
- R2: At scale code 00 the output equals the square root of `x_mag² + y_mag²` in input LSB units, so the pair (0x8000, 0x8000) gives 46340.
- R3: The square root is truncated toward zero, giving the largest integer whose square does not exceed the sum. The pair (3, 4) gives exactly 5, and the pair (1, 1) gives 1.
- R4: The result for a pair captured at rising edge n is on `mag_out` from rising edge n+23 onward, which is 24 edges counting the capture edge. Consecutive pairs give consecutive results.
- R5: Scale codes select the multiplier. 00 gives ×1, 01 gives ×2, 10 gives ×4 and 11 gives ×8, each a left shift of 0, 1, 2 or 3 places.
- R6: `scale_sel` is registered at a rising edge. The output word loaded at the next rising edge uses it, independently of which data that word carries.
- R7: `ovf_out` is 1 exactly when the shifted value has a 1 above bit 15. In that case `mag_out` holds bits 15..0 of the shifted value.
- R8: The asynchronous active-low reset clears every stage. `mag_out` and `ovf_out` read 0 during reset and for the first 23 edges after it.
- R9: A zero pair yields `mag_out` = 0 with `ovf_out` = 0 under every scale code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_mag | input | 16 | First component magnitude, 0..0x8000 |
| y_mag | input | 16 | Second component magnitude, 0..0x8000 |
| scale_sel | input | 2 | Output scale code (00 ×1, 01 ×2, 10 ×4, 11 ×8) |
| mag_out | output | 16 | Scaled vector length |
| ovf_out | output | 1 | Set while `mag_out` has lost significant bits to the shift |

## Verification
The data and the scale control reach the output on different schedules. A pair captured at edge n shows up after edge n+23, while a scale code captured at edge m shapes the word loaded at edge m+1. The bench keeps a per-edge history of both and, half a period after each edge c, compares the output with the pair from edge c−23 scaled by the code from edge c−1. Before edge 24 it expects the cleared value. Because the scale code changes on almost every cycle, a scale path that were delayed alongside the data would pair the wrong code with a word and be caught.

// File: rtl/pyth_mag_pkg.sv
package pyth_mag_pkg;

  // Default geometry of the magnitude unit
  localparam int unsigned MAG_IN_W   = 16;
  localparam int unsigned MAG_OUT_W  = 16;
  localparam int unsigned MAG_LAT    = 24;
  localparam int unsigned SCALE_W    = 2;
  localparam int unsigned SCALE_MAXS = 3;

  // Output scale codes
  typedef enum logic [SCALE_W-1:0] {
    SCL_X1 = 2'b00,
    SCL_X2 = 2'b01,
    SCL_X4 = 2'b10,
    SCL_X8 = 2'b11
  } scale_e;

  // Number of left shift places selected by a scale code
  function automatic int unsigned shift_places(input scale_e code);
    case (code)
      SCL_X1:  return 0;
      SCL_X2:  return 1;
      SCL_X4:  return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/pyth_mag_square_sum.sv
module pyth_mag_square_sum #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SUM_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  output logic [SUM_W-1:0]  sum_out
);

  // Three register ranks: capture, square, add
  logic [DATA_W-1:0] x_q, y_q;
  logic [SUM_W-1:0]  xx_q, yy_q, sum_q;

  function automatic logic [SUM_W-1:0] square_of(input logic [DATA_W-1:0] v);
    logic [SUM_W-1:0] w;
    w = SUM_W'(v);
    return w * w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      xx_q  <= '0;
      yy_q  <= '0;
      sum_q <= '0;
    end else begin
      x_q   <= x_in;
      y_q   <= y_in;
      xx_q  <= square_of(x_q);
      yy_q  <= square_of(y_q);
      sum_q <= xx_q + yy_q;
    end
  end

  assign sum_out = sum_q;

  // R9: a captured zero pair reaches the sum rank as zero two edges later
  p_zero_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (x_q == '0 && y_q == '0) |=> ##1 (sum_q == '0));

endmodule

// File: rtl/pyth_mag_sqrt_pipe.sv
module pyth_mag_sqrt_pipe #(
  parameter int unsigned SUM_W  = 32,
  parameter int unsigned ROOT_W = SUM_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUM_W-1:0]  rad_in,
  output logic [ROOT_W-1:0] root_out
);

  localparam int unsigned REM_W = ROOT_W + 4;
  localparam int unsigned EXT_W = REM_W + 2;
  localparam int unsigned PADQ  = EXT_W - ROOT_W - 2;
  localparam int unsigned CHK_W = SUM_W + 2;

  // Stage state: signed partial remainder, partial root, radicand bits still
  // to consume, and the untouched radicand kept for the result check
  logic signed [REM_W-1:0] rem_s  [0:ROOT_W];
  logic [ROOT_W-1:0]       root_s [0:ROOT_W];
  logic [SUM_W-1:0]        rad_s  [0:ROOT_W];
  logic [SUM_W-1:0]        src_s  [0:ROOT_W];

  // One non-restoring step: bring in two radicand bits, then subtract or add
  // depending on the sign of the previous remainder
  function automatic logic signed [REM_W-1:0] nr_step(
    input logic signed [REM_W-1:0] rem,
    input logic [ROOT_W-1:0]       root,
    input logic [1:0]              pair
  );
    logic signed [EXT_W-1:0] shifted, trial, result;
    shifted = {rem, pair};
    if (rem >= 0) begin
      trial  = {{PADQ{1'b0}}, root, 2'b01};
      result = shifted - trial;
    end else begin
      trial  = {{PADQ{1'b0}}, root, 2'b11};
      result = shifted + trial;
    end
    return result[REM_W-1:0];
  endfunction

  assign rem_s[0]  = '0;
  assign root_s[0] = '0;
  assign rad_s[0]  = rad_in;
  assign src_s[0]  = rad_in;

  for (genvar i = 0; i < ROOT_W; i++) begin : g_stage
    logic signed [REM_W-1:0] rem_next_w;
    logic                    root_bit_w;

    assign rem_next_w = nr_step(rem_s[i], root_s[i], rad_s[i][SUM_W-1 -: 2]);
    assign root_bit_w = ~rem_next_w[REM_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rem_s[i+1]  <= '0;
        root_s[i+1] <= '0;
        rad_s[i+1]  <= '0;
        src_s[i+1]  <= '0;
      end else begin
        rem_s[i+1]  <= rem_next_w;
        root_s[i+1] <= {root_s[i][ROOT_W-2:0], root_bit_w};
        rad_s[i+1]  <= {rad_s[i][SUM_W-3:0], 2'b00};
        src_s[i+1]  <= src_s[i];
      end
    end
  end

  assign root_out = root_s[ROOT_W];

  // Square of the final root and of its successor, for the floor check
  logic [CHK_W-1:0] root_sq_w, next_sq_w, src_ext_w;
  assign root_sq_w = CHK_W'(root_s[ROOT_W]) * CHK_W'(root_s[ROOT_W]);
  assign next_sq_w = (CHK_W'(root_s[ROOT_W]) + 1'b1) * (CHK_W'(root_s[ROOT_W]) + 1'b1);
  assign src_ext_w = CHK_W'(src_s[ROOT_W]);

  // R3: the final root is the largest integer whose square fits the radicand
  p_root_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (root_sq_w <= src_ext_w) && (next_sq_w > src_ext_w));

endmodule

// File: rtl/pyth_mag_scaler.sv
module pyth_mag_scaler
  import pyth_mag_pkg::*;
#(
  parameter int unsigned ROOT_W = 16,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned PAD    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROOT_W-1:0]  root_in,
  input  logic [SCALE_W-1:0] scale_sel,
  output logic [OUT_W-1:0]   mag_out,
  output logic               ovf_out
);

  localparam int unsigned SH_W = ROOT_W + SCALE_MAXS;

  // Delay ranks that align the root with the required latency
  logic [ROOT_W-1:0] pad_r [0:PAD];
  assign pad_r[0] = root_in;

  for (genvar i = 0; i < PAD; i++) begin : g_pad
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pad_r[i+1] <= '0;
      else        pad_r[i+1] <= pad_r[i];
    end
  end

  logic [ROOT_W-1:0] pad_out_w;
  assign pad_out_w = pad_r[PAD];

  // Scale code has its own single register, outside the data pipeline
  scale_e scale_q;

  function automatic logic [SH_W-1:0] scale_up(input logic [ROOT_W-1:0] v,
                                               input scale_e code);
    return SH_W'(v) << shift_places(code);
  endfunction

  logic [SH_W-1:0]        shifted_w;
  logic [SH_W-OUT_W-1:0]  lost_bits_w;
  logic                   lost_any_w;

  assign shifted_w   = scale_up(pad_out_w, scale_q);
  assign lost_bits_w = shifted_w[SH_W-1:OUT_W];
  assign lost_any_w  = |lost_bits_w;

  logic [OUT_W-1:0] mag_q;
  logic             ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= SCL_X1;
      mag_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      scale_q <= scale_e'(scale_sel);
      mag_q   <= shifted_w[OUT_W-1:0];
      ovf_q   <= lost_any_w;
    end
  end

  assign mag_out = mag_q;
  assign ovf_out = ovf_q;

  // R7: with the flag clear, undoing the shift recovers the root exactly
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_out |-> ((SH_W'(mag_out) >> $past(shift_places(scale_q))) == SH_W'($past(pad_out_w))));

  // R7: a raised flag means the root was at or above the limit for that shift
  p_overflow_big_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_out |-> ((SH_W'($past(pad_out_w)) << $past(shift_places(scale_q))) >= (SH_W'(1) << OUT_W)));

  // R5: at scale x1 the word is never flagged
  p_unit_scale_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scale_q) == SCL_X1) |-> !ovf_out);

endmodule

// File: rtl/pyth_mag_unit.sv
module pyth_mag_unit
  import pyth_mag_pkg::*;
#(
  parameter int unsigned IN_W    = MAG_IN_W,
  parameter int unsigned OUT_W   = MAG_OUT_W,
  parameter int unsigned LATENCY = MAG_LAT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IN_W-1:0]    x_mag,
  input  logic [IN_W-1:0]    y_mag,
  input  logic [SCALE_W-1:0] scale_sel,
  output logic [OUT_W-1:0]   mag_out,
  output logic               ovf_out
);

  localparam int unsigned SUM_W      = 2 * IN_W;
  localparam int unsigned ROOT_W     = SUM_W / 2;
  localparam int unsigned FRONT_RANK = 3;
  localparam int unsigned OUT_RANK   = 1;
  localparam int unsigned PAD        = LATENCY - FRONT_RANK - ROOT_W - OUT_RANK;

  logic [SUM_W-1:0]  sum_w;
  logic [ROOT_W-1:0] root_w;

  pyth_mag_square_sum #(
    .DATA_W (IN_W),
    .SUM_W  (SUM_W)
  ) u_sqsum (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_in    (x_mag),
    .y_in    (y_mag),
    .sum_out (sum_w)
  );

  pyth_mag_sqrt_pipe #(
    .SUM_W  (SUM_W),
    .ROOT_W (ROOT_W)
  ) u_sqrt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rad_in   (sum_w),
    .root_out (root_w)
  );

  pyth_mag_scaler #(
    .ROOT_W (ROOT_W),
    .OUT_W  (OUT_W),
    .PAD    (PAD)
  ) u_scale (
    .clk       (clk),
    .rst_n     (rst_n),
    .root_in   (root_w),
    .scale_sel (scale_sel),
    .mag_out   (mag_out),
    .ovf_out   (ovf_out)
  );

endmodule

// File: tb/pyth_mag_unit_tb_top.sv
module pyth_mag_unit_tb_top;

  localparam int TOTAL = 2300;
  localparam int LAT   = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] x_mag, y_mag;
  logic [1:0]  scale_sel;
  logic [15:0] mag_out;
  logic        ovf_out;

  always #4 clk = ~clk;

  pyth_mag_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_mag     (x_mag),
    .y_mag     (y_mag),
    .scale_sel (scale_sel),
    .mag_out   (mag_out),
    .ovf_out   (ovf_out)
  );

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  // Values present before each rising edge, indexed by edge number
  logic [15:0] xh [0:4095];
  logic [15:0] yh [0:4095];
  logic [1:0]  sh [0:4095];

  // Reference root by bisection on the square
  function automatic longint unsigned ref_root(input longint unsigned v);
    longint unsigned lo = 0, hi = 65536, mid;
    while (hi - lo > 1) begin
      mid = (lo + hi) / 2;
      if (mid * mid <= v) lo = mid;
      else                hi = mid;
    end
    return lo;
  endfunction

  function automatic longint unsigned ref_scaled(input logic [15:0] a, input logic [15:0] b,
                                                 input logic [1:0] code);
    longint unsigned r;
    r = ref_root(longint'(a) * longint'(a) + longint'(b) * longint'(b));
    return r * (longint'(1) << code);
  endfunction

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  function automatic logic [15:0] rnd_range(input int unsigned lo, input int unsigned hi);
    return 16'($urandom_range(hi, lo));
  endfunction

  // Stimulus: directed corners, then R1-range random, small and near-full phases
  initial begin
    void'($urandom(32'd731));
    for (int e = 0; e < 4096; e++) begin
      xh[e] = '0; yh[e] = '0; sh[e] = 2'($urandom_range(3, 0));
    end
    xh[1]  = 16'h0000; yh[1]  = 16'h0000;
    xh[2]  = 16'h8000; yh[2]  = 16'h8000;
    xh[3]  = 16'h8000; yh[3]  = 16'h8000;
    xh[4]  = 16'h8000; yh[4]  = 16'h0000;
    xh[5]  = 16'h7FFF; yh[5]  = 16'h0000;
    xh[6]  = 16'd3;    yh[6]  = 16'd4;
    xh[7]  = 16'd1;    yh[7]  = 16'd1;
    xh[8]  = 16'h0000; yh[8]  = 16'h8000;
    xh[9]  = 16'h7FFF; yh[9]  = 16'h7FFF;
    xh[10] = 16'h0000; yh[10] = 16'h0000;
    xh[11] = 16'h2000; yh[11] = 16'h2000;
    xh[12] = 16'h0000; yh[12] = 16'h0000;
    // Scale codes aligned so directed pairs see a fixed rotation of all codes
    for (int c = 1; c <= 12; c++) sh[c + LAT - 2] = 2'((c - 1) % 4);
    sh[LAT - 1 + 1] = 2'd0;   // pair 2 at x1
    sh[LAT - 1 + 2] = 2'd1;   // pair 3 at x2 (overflow)
    sh[LAT - 1 + 3] = 2'd1;   // pair 4 at x2 (overflow, low word 0)
    sh[LAT - 1 + 4] = 2'd1;   // pair 5 at x2 (no overflow)
    sh[LAT - 1 + 9] = 2'd3;   // pair 10 zero at x8
    sh[LAT - 1 + 11] = 2'd2;  // pair 12 zero at x4
    for (int c = 13; c <= TOTAL; c++) begin
      if (c <= 1000) begin
        xh[c] = rnd_range(0, 32768); yh[c] = rnd_range(0, 32768);
      end else if (c <= 1600) begin
        xh[c] = rnd_range(0, 255);   yh[c] = rnd_range(0, 255);
      end else begin
        xh[c] = rnd_range(28672, 32768); yh[c] = rnd_range(28672, 32768);
      end
    end
  end

  // Main sequence
  initial begin
    rst_n     = 1'b0;
    x_mag     = 16'h1234;
    y_mag     = 16'h4321;
    scale_sel = 2'd3;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R8", "mag during reset", mag_out, 0);
    chk("R8", "ovf during reset", ovf_out, 0);
    x_mag     = xh[1];
    y_mag     = yh[1];
    scale_sel = sh[1];
    rst_n     = 1'b1;
    for (int c = 1; c <= TOTAL + LAT; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c < LAT) begin
        chk("R8", "mag before first result", mag_out, 0);
        chk("R8", "ovf before first result", ovf_out, 0);
      end else begin
        longint unsigned s;
        logic [15:0] a, b;
        a = xh[c - LAT + 1];
        b = yh[c - LAT + 1];
        s = ref_scaled(a, b, sh[c - 1]);
        if (a == 0 && b == 0) begin
          chk("R9", "mag for zero pair", mag_out, 0);
          chk("R9", "ovf for zero pair", ovf_out, 0);
        end else begin
          chk("R1 R2 R3 R4 R5 R6", "mag", mag_out, s & 64'hFFFF);
          chk("R7", "ovf", ovf_out, (s >> 16) != 0 ? 1 : 0);
        end
      end
      x_mag     = xh[c + 1];
      y_mag     = yh[c + 1];
      scale_sel = sh[c + 1];
    end
    done = 1'b1;
    summary();
    $finish;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule